// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a 24-bit down-counting tick timer for a processor subsystem. Software reaches it over a small 32-bit register bus. Each access carries an address, a read or write strobe, write data and a privilege flag. The block answers with read data and an error flag one cycle later.

The counter steps down once per selected tick. The tick is either every core-clock cycle or a one-cycle reference enable pulse that is already synchronous to the core clock. When the count steps from one to zero, the block sets a sticky wrap flag. If interrupts are enabled, it also emits a one-cycle interrupt request. On the following tick the count reloads from the reload register.

A read-only calibration word is built from parameters. The timer is used as the periodic time base of an operating system.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word reads 0 (0x4 when no reference clock is built in), and the reload and current-value registers read 0.
- R2: In the control word at offset 0x0, bit 0 is run, bit 1 is interrupt enable, bit 2 is tick source (1 = core clock) and bit 16 is the wrap flag. Writes change only bits 2:0.
- R3: The reload register at offset 0x4 keeps the low 24 bits of a write and reads bits 31:24 as zero.
- R4: While running, the count at offset 0x8 drops by one per tick. A tick is every cycle when the source bit is 1, and a reference pulse when it is 0. A tick at count 0 loads the reload value, so the period is reload+1 ticks.
- R5: A step from 1 to 0 sets the wrap flag. It raises the interrupt output for exactly one cycle only when interrupt enable is 1.
- R6: A read of the control word returns the wrap flag and then clears it.
- R7: Any write to offset 0x8 sets the count to 0 and clears the wrap flag.
- R8: A tick at count 0 with reload 0 halts counting, and the run bit stays 1. Counting resumes only after the run bit is written 0 and then 1.
- R9: Offset 0xC reads {no-reference bit 31, inexact bit 30, zeros, 24-bit ten-millisecond count minus one}. Without a reference clock it reads 0x80000000.
- R10: Without a reference clock, the source bit reads 1 after reset and after every control write.
- R11: An access with the privilege flag low returns error 1 and read data 0, and changes no state.
- R12: Reads of other offsets return 0 with no error. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | Synchronous reference tick enable pulse |
| busAddr | input | 8 | Byte offset of the access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busPriv | input | 1 | Access is privileged |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| busErr | output | 1 | Error response, valid the cycle after the strobe |
| tickIrq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The hardest state to reach is a timer that is halted while its run bit is still set. To get there, the count has to be walked down to zero with a zero reload, a nonzero reload has to be written afterwards, and the count must still stay at zero. The bench counts on reference pulses that it issues one at a time, so every count value is known before each read. It then toggles the run bit to show that counting restarts. A short stretch on the core clock measures the reload+1 interrupt spacing. A second instance built without a reference clock covers the forced source bit and the calibration fallback.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned OFF_CTRL   = 'h0;
  localparam int unsigned OFF_RELOAD = 'h4;
  localparam int unsigned OFF_COUNT  = 'h8;
  localparam int unsigned OFF_CAL    = 'hC;

  typedef struct packed {
    logic tick;      // selected tick this cycle
    logic run;       // run bit
    logic startRun;  // run bit going 0 -> 1
    logic reloadWr;  // privileged reload write
    logic countClr;  // privileged current-value write
  } dpCtl_t;
endpackage

// File: rtl/tick_datapath.sv
module tick_datapath #(
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  tick_pkg::dpCtl_t   ctl,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   reload,
  output logic               wrapEv
);
  logic [CNT_W-1:0] countQ, reloadQ;
  logic haltQ;
  logic stepOk;

  assign stepOk = ctl.run && !haltQ && ctl.tick && !ctl.countClr;
  assign wrapEv = stepOk && (countQ == CNT_W'(1));
  assign count  = countQ;
  assign reload = reloadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (ctl.reloadWr) begin
      reloadQ <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      haltQ  <= 1'b0;
    end else begin
      if (ctl.startRun) haltQ <= 1'b0;
      if (ctl.countClr) begin
        countQ <= '0;
        if (reloadQ == '0) haltQ <= 1'b1;
      end else if (stepOk) begin
        if (countQ == '0) begin
          if (reloadQ == '0) haltQ <= 1'b1;
          else countQ <= reloadQ;
        end else begin
          countQ <= countQ - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl #(
  parameter int          ADDR_W    = 8,
  parameter int          CNT_W     = 24,
  parameter bit          HAS_REF   = 1'b1,
  parameter bit          CAL_SKEW  = 1'b0,
  parameter logic [23:0] CAL_TENMS = 24'd9999
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [2:0]         ctlBits,
  input  logic               busPriv,
  input  logic [CNT_W-1:0]   count,
  input  logic [CNT_W-1:0]   reload,
  input  logic               wrapEv,
  output tick_pkg::dpCtl_t   dpCtl,
  output logic [31:0]        busRdata,
  output logic               busErr,
  output logic               tickIrq,
  output logic               wrapFlag
);
  import tick_pkg::*;

  localparam logic [31:0] CAL_WORD = HAS_REF ?
    {1'b0, CAL_SKEW, 6'b0, CAL_TENMS} : 32'h8000_0000;
  localparam logic SRC_RESET = !HAS_REF;

  logic enableQ, tickIntQ, srcQ, flagQ, irqQ, errQ;
  logic [31:0] rdataQ, rdMux;
  logic wrOk, rdOk;
  logic selCtrl, selReload, selCount, selCal;
  logic ctrlWr, srcNext;

  assign wrOk      = busWr && busPriv;
  assign rdOk      = busRd && busPriv;
  assign selCtrl   = busAddr == ADDR_W'(OFF_CTRL);
  assign selReload = busAddr == ADDR_W'(OFF_RELOAD);
  assign selCount  = busAddr == ADDR_W'(OFF_COUNT);
  assign selCal    = busAddr == ADDR_W'(OFF_CAL);
  assign ctrlWr    = wrOk && selCtrl;
  assign srcNext   = HAS_REF ? ctlBits[2] : 1'b1;

  always_comb begin
    dpCtl.tick     = srcQ ? 1'b1 : refTick;
    dpCtl.run      = enableQ;
    dpCtl.startRun = ctrlWr && ctlBits[0] && !enableQ;
    dpCtl.reloadWr = wrOk && selReload;
    dpCtl.countClr = wrOk && selCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      tickIntQ <= 1'b0;
      srcQ     <= SRC_RESET;
    end else if (ctrlWr) begin
      enableQ  <= ctlBits[0];
      tickIntQ <= ctlBits[1];
      srcQ     <= srcNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      irqQ <= wrapEv && tickIntQ;
      if (wrapEv) flagQ <= 1'b1;
      else if (dpCtl.countClr || (rdOk && selCtrl)) flagQ <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    if (selCtrl)   rdMux = {15'b0, flagQ, 13'b0, srcQ, tickIntQ, enableQ};
    if (selReload) rdMux = {{(32-CNT_W){1'b0}}, reload};
    if (selCount)  rdMux = {{(32-CNT_W){1'b0}}, count};
    if (selCal)    rdMux = CAL_WORD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else begin
      rdataQ <= rdOk ? rdMux : '0;
      errQ   <= (busRd || busWr) && !busPriv;
    end
  end

  assign busRdata = rdataQ;
  assign busErr   = errQ;
  assign tickIrq  = irqQ;
  assign wrapFlag = flagQ;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          ADDR_W    = 8,
  parameter int          CNT_W     = 24,
  parameter bit          HAS_REF   = 1'b1,
  parameter bit          CAL_SKEW  = 1'b0,
  parameter logic [23:0] CAL_TENMS = 24'd9999
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  input  logic              busPriv,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              tickIrq
);
  tick_pkg::dpCtl_t dpCtl;
  logic [CNT_W-1:0] countVal, reloadVal;
  logic wrapEv, wrapFlag;

  tick_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HAS_REF(HAS_REF),
    .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .ctlBits(busWdata[2:0]),
    .busPriv(busPriv), .count(countVal), .reload(reloadVal),
    .wrapEv(wrapEv), .dpCtl(dpCtl), .busRdata(busRdata),
    .busErr(busErr), .tickIrq(tickIrq), .wrapFlag(wrapFlag)
  );

  tick_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .wdata(busWdata[CNT_W-1:0]),
    .count(countVal), .reload(reloadVal), .wrapEv(wrapEv)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic              busPriv,
  input logic              busErr,
  input logic              tickIrq,
  input logic              wrapFlag,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  reloadVal
);
  // R5: interrupt lasts exactly one cycle
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq);

  // R5: interrupt only accompanies a set wrap flag
  assert_irq_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> wrapFlag);

  // R11: error only after an unprivileged access
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past((busRd || busWr) && !busPriv));

  // R11: unprivileged write leaves reload alone
  assert_unpriv_reload_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busPriv) |=> $stable(reloadVal));

  // R7: current-value write zeroes count and flag
  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busPriv && busAddr == ADDR_W'(8)) |=> (countVal == '0 && !wrapFlag));

  // R8: a zero count with zero reload never leaves zero without a reload write
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0 && reloadVal == '0 && !busWr) |=> countVal == '0);
endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busPriv(busPriv), .busErr(busErr), .tickIrq(tickIrq), .wrapFlag(wrapFlag),
  .countVal(countVal), .reloadVal(reloadVal)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b0;
  logic [7:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0, busPriv = 1'b1;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, rdataN;
  logic busErr, errN, tickIrq, irqN;
  int total = 0, bad = 0;
  int cyc = 0;
  logic rdSeen = 1'b0;

  typedef struct { logic [31:0] data; logic err; string tag; } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busPriv(busPriv),
    .busRdata(busRdata), .busErr(busErr), .tickIrq(tickIrq)
  );

  tick_timer #(.HAS_REF(1'b0)) u_tick_timer_noref (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .busPriv(busPriv),
    .busRdata(rdataN), .busErr(errN), .tickIrq(irqN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdSeen <= busRd;
  end

  // monitor: compare read responses against the scoreboard
  always @(negedge clk) begin
    if (rdSeen) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "scoreboard-empty", busRdata, 32'h0);
      end else begin
        expItem_t e;
        e = sbQ.pop_front();
        check(busRdata == e.data, e.tag, busRdata, e.data);
        check(busErr == e.err, {e.tag, "-err"}, {31'b0, busErr}, {31'b0, e.err});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    busAddr = a; busWdata = d; busPriv = p; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busPriv = 1'b1;
  endtask

  task automatic rdExp(input logic [7:0] a, input logic p, input logic [31:0] d,
                       input logic e, input string tag);
    expItem_t it;
    it.data = d; it.err = e; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    busAddr = a; busPriv = p; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0; busPriv = 1'b1;
  endtask

  task automatic pulse(output logic irqSeen);
    @(negedge clk);
    refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
    irqSeen = tickIrq;
  endtask

  initial begin
    logic irq;
    int t1, t2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R9 / R10 reset state and calibration
    check(tickIrq == 1'b0, "R1 irq idle", {31'b0, tickIrq}, 32'h0);
    rdExp(8'h0, 1'b1, 32'h0, 1'b0, "R1 ctrl reset");
    check(rdataN == 32'h4, "R10 noref ctrl reset", rdataN, 32'h4);
    rdExp(8'h4, 1'b1, 32'h0, 1'b0, "R1 reload reset");
    rdExp(8'h8, 1'b1, 32'h0, 1'b0, "R1 count reset");
    rdExp(8'hC, 1'b1, 32'h0000_270F, 1'b0, "R9 calibration");
    check(rdataN == 32'h8000_0000, "R9 noref calibration", rdataN, 32'h8000_0000);

    // R2 only low three bits writable; R10 forced source
    wr(8'h0, 32'hFFFF_FFFA, 1'b1);
    rdExp(8'h0, 1'b1, 32'h2, 1'b0, "R2 writable bits");
    check(rdataN == 32'h6, "R10 noref forced source", rdataN, 32'h6);
    wr(8'h0, 32'h0, 1'b1);

    // R3 reload width
    wr(8'h4, 32'hFF00_0003, 1'b1);
    rdExp(8'h4, 1'b1, 32'h3, 1'b0, "R3 reload upper discarded");

    // R4 / R5 / R6 counting on reference pulses
    wr(8'h0, 32'h3, 1'b1);
    pulse(irq);
    check(irq == 1'b0, "R4 load no irq", {31'b0, irq}, 32'h0);
    rdExp(8'h8, 1'b1, 32'h3, 1'b0, "R4 loaded");
    pulse(irq); pulse(irq);
    rdExp(8'h8, 1'b1, 32'h1, 1'b0, "R4 decrement");
    pulse(irq);
    check(irq == 1'b1, "R5 irq on wrap", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check(tickIrq == 1'b0, "R5 irq one cycle", {31'b0, tickIrq}, 32'h0);
    rdExp(8'h0, 1'b1, 32'h0001_0003, 1'b0, "R6 flag set");
    rdExp(8'h0, 1'b1, 32'h3, 1'b0, "R6 flag cleared by read");
    pulse(irq);
    rdExp(8'h8, 1'b1, 32'h3, 1'b0, "R4 reload next tick");
    repeat (10) @(negedge clk);
    rdExp(8'h8, 1'b1, 32'h3, 1'b0, "R4 idle without reference pulse");

    // R5 no interrupt when disabled
    wr(8'h0, 32'h1, 1'b1);
    pulse(irq); pulse(irq); pulse(irq);
    check(irq == 1'b0, "R5 no irq when disabled", {31'b0, irq}, 32'h0);
    rdExp(8'h0, 1'b1, 32'h0001_0001, 1'b0, "R5 flag without irq");

    // R7 current-value write
    wr(8'h0, 32'h3, 1'b1);
    pulse(irq); pulse(irq); pulse(irq); pulse(irq); pulse(irq);
    wr(8'h8, 32'h0000_ABCD, 1'b1);
    rdExp(8'h8, 1'b1, 32'h0, 1'b0, "R7 count zeroed");
    rdExp(8'h0, 1'b1, 32'h3, 1'b0, "R7 flag cleared");

    // R11 unprivileged access
    wr(8'h4, 32'h7, 1'b0);
    check(busErr == 1'b1, "R11 write error", {31'b0, busErr}, 32'h1);
    rdExp(8'h4, 1'b1, 32'h3, 1'b0, "R11 reload unchanged");
    rdExp(8'h8, 1'b0, 32'h0, 1'b1, "R11 read error");
    wr(8'h0, 32'h0, 1'b0);
    rdExp(8'h0, 1'b1, 32'h3, 1'b0, "R11 ctrl unchanged");

    // R12 unmapped offsets
    rdExp(8'h10, 1'b1, 32'h0, 1'b0, "R12 unmapped read");
    wr(8'h10, 32'hFFFF_FFFF, 1'b1);
    rdExp(8'h0, 1'b1, 32'h3, 1'b0, "R12 unmapped write ctrl");
    rdExp(8'h4, 1'b1, 32'h3, 1'b0, "R12 unmapped write reload");

    // R4 core clock period reload+1
    wr(8'h0, 32'h7, 1'b1);
    t1 = -1; t2 = -1;
    for (int i = 0; i < 40 && t2 < 0; i++) begin
      @(negedge clk);
      if (tickIrq) begin
        if (t1 < 0) t1 = cyc; else t2 = cyc;
      end
    end
    check(t2 - t1 == 4, "R4 core clock period", t2 - t1, 32'd4);
    wr(8'h0, 32'h3, 1'b1);

    // R8 zero reload halts with run bit kept
    wr(8'h8, 32'h0, 1'b1);
    pulse(irq);
    wr(8'h4, 32'h0, 1'b1);
    pulse(irq); pulse(irq); pulse(irq);
    check(irq == 1'b1, "R8 final expiry irq", {31'b0, irq}, 32'h1);
    pulse(irq);
    check(irq == 1'b0, "R8 no irq when halted", {31'b0, irq}, 32'h0);
    rdExp(8'h8, 1'b1, 32'h0, 1'b0, "R8 count held");
    rdExp(8'h0, 1'b1, 32'h0001_0003, 1'b0, "R8 run bit kept");
    wr(8'h4, 32'h2, 1'b1);
    pulse(irq);
    rdExp(8'h8, 1'b1, 32'h0, 1'b0, "R8 stays halted");
    wr(8'h0, 32'h0, 1'b1);
    wr(8'h0, 32'h3, 1'b1);
    pulse(irq);
    rdExp(8'h8, 1'b1, 32'h2, 1'b0, "R8 restart");

    repeat (4) @(negedge clk);
    check(sbQ.size() == 0, "scoreboard drained", sbQ.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule